// File: doc/BRIEF.md
# Timer Pin Control and Edge Event Unit

This block owns the single I/O pin of one timer channel. Software writes a mode register to choose what the pin does: it can stay idle, act as a plain general-purpose pin (driven low, driven high, or left as an input, with an optional open-drain style), or act as an input-capture pin. In input-capture mode the block watches the pin for a rising edge, a falling edge or either edge.

A selected edge sets a sticky event flag in a status register. Software clears that flag by writing a one to it. An interrupt line is raised while the interrupt enable is on and any flag is set. Edge events are also recorded while the pin serves as a general-purpose input, so the pin can be read and used as an interrupt source at the same time. The status register also shows the live pin level after synchronization.

Counting, prescaling and watchdog duties sit in a neighbouring timer block. The bus here is a single-cycle write strobe with a combinational read port that decodes two register offsets.

Top module: `tmr_pin_unit`

## Requirements
- R1: After reset the mode register reads 0, the status register reads 0 apart from the pin level in bit 8, `pin_oe` is 0 and `irq` is 0.
- R2: Mode reads return exactly the writable bits, mask 0x0003_0337: function bits 2:0, output bits 5:4, interrupt enable bit 8, open-drain bit 9 and edge select bits 17:16. Every other bit reads 0.
- R3: The pin is driven only when the function field is 4 (GPIO). In that mode, output field 10 drives low, 11 drives high, and 00 or 01 leaves the pin undriven. Function values 0, 1, 2 and 3 never drive the pin.
- R4: When open-drain bit 9 is set in GPIO mode, a high output releases the pin (`pin_oe`=0) and a low output still drives it low.
- R5: Edge select bits 17:16 choose which edges are recorded: 01 records rising edges, 10 records falling edges, 11 records both, and 00 records none. A recorded edge sets status bit 0 SYNC_STAGES+1 clock edges after the pin changes.
- R6: Edges are recorded only while the function field is 1 (input capture) or 4 (GPIO). With function 0, no event is recorded.
- R7: Writing the status offset clears every flag in bits 3:0 whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R8: If an edge is recorded in the same cycle that a write clears flag 0, flag 0 stays set.
- R9: `irq` is 1 exactly when mode bit 8 is 1 and at least one status flag is 1.
- R10: Status bit 8 reads the pin level delayed by SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset; mode at MODE_OFS, status at STAT_OFS |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| pin_in | input | 1 | Asynchronous pin level |
| pin_out | output | 1 | Level driven when `pin_oe` is 1 |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This makes the capture latency and the live-level lag differ from any hard-coded two-flop assumption. The bench computes every sampling point from that parameter, so the collision case, where a clear write lands on the exact cycle the edge is recognised, is placed by arithmetic and not by a fixed delay. The default offsets and data width are kept, so the register bit positions match the requirements directly.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
  localparam int FN_LSB   = 0;
  localparam int OUT_LSB  = 4;
  localparam int IE_BIT   = 8;
  localparam int OD_BIT   = 9;
  localparam int EDGE_LSB = 16;
  localparam int LVL_BIT  = 8;
  localparam logic [31:0] MODE_WMASK = 32'h0003_0337;

  localparam logic [2:0] FN_OFF     = 3'd0;
  localparam logic [2:0] FN_CAPTURE = 3'd1;
  localparam logic [2:0] FN_GPIO    = 3'd4;

  typedef struct packed {
    logic oe;
    logic lvl;
  } drive_t;

  function automatic logic edge_match(logic [1:0] sel, logic cur, logic prv);
    return (sel[0] & cur & ~prv) | (sel[1] & ~cur & prv);
  endfunction

  function automatic drive_t drive_decode(logic [2:0] fn, logic [1:0] outf, logic od);
    drive_t d;
    d.lvl = outf[0];
    d.oe  = (fn == FN_GPIO) && outf[1] && !(od && outf[0]);
    return d;
  endfunction

  function automatic logic capture_armed(logic [2:0] fn);
    return (fn == FN_CAPTURE) || (fn == FN_GPIO);
  endfunction
endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= 1'b0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= 1'b0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tpin_event.sv
module tpin_event
  import tpin_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl,
  input  logic              armed,
  input  logic [1:0]        sel,
  input  logic [FLAG_W-1:0] clr,
  output logic [FLAG_W-1:0] flags,
  output logic              hit,
  output logic              prev
);
  logic [FLAG_W-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  assign hit     = armed & edge_match(sel, lvl, prev);
  assign set_vec = {{(FLAG_W-1){1'b0}}, hit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set_vec;
endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
  import tpin_pkg::*;
(
  input  logic [2:0] fn,
  input  logic [1:0] outf,
  input  logic       od,
  output logic       pin_out,
  output logic       pin_oe
);
  drive_t d;

  always_comb begin
    d       = drive_decode(fn, outf, od);
    pin_out = d.lvl;
    pin_oe  = d.oe;
  end
endmodule

// File: rtl/tmr_pin_unit.sv
module tmr_pin_unit
  import tpin_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int MODE_OFS    = 0,
  parameter int STAT_OFS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  localparam logic [DATA_W-1:0] WMASK = DATA_W'(MODE_WMASK);

  logic [DATA_W-1:0] mode_q;
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] stat_clr;
  logic              mode_wr, stat_wr;
  logic              pin_sync, pin_prev, edge_hit;
  logic [2:0]        fn;

  assign mode_wr  = bus_wr && (bus_addr == ADDR_W'(MODE_OFS));
  assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(STAT_OFS));
  assign stat_clr = stat_wr ? bus_wdata[FLAG_W-1:0] : '0;
  assign fn       = mode_q[FN_LSB +: 3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= bus_wdata & WMASK;

  tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  tpin_event #(.FLAG_W(FLAG_W)) u_event (
    .clk(clk), .rst_n(rst_n), .lvl(pin_sync),
    .armed(capture_armed(fn)), .sel(mode_q[EDGE_LSB +: 2]),
    .clr(stat_clr), .flags(flags_q), .hit(edge_hit), .prev(pin_prev)
  );

  tpin_drive u_drive (
    .fn(fn), .outf(mode_q[OUT_LSB +: 2]), .od(mode_q[OD_BIT]),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign irq = mode_q[IE_BIT] & (|flags_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(MODE_OFS)) begin
      bus_rdata = mode_q;
    end else if (bus_addr == ADDR_W'(STAT_OFS)) begin
      bus_rdata[FLAG_W-1:0] = flags_q;
      bus_rdata[LVL_BIT]    = pin_sync;
    end
  end
endmodule

// File: rtl/tmr_pin_unit_chk.sv
module tmr_pin_unit_chk #(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] mode_q,
  input logic [FLAG_W-1:0] flags_q,
  input logic              stat_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              edge_hit,
  input logic              pin_sync,
  input logic              pin_prev,
  input logic              pin_oe,
  input logic              irq
);
  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mode_q[8]);
  // R3
  undriven_outside_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] != 3'd4) |-> !pin_oe);
  // R4
  od_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[9] && mode_q[5:4] == 2'b11) |-> !pin_oe);
  // R8
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flags_q[0]);
  // R7
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[0] && !edge_hit) |=> !flags_q[0]);
  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && !edge_hit) |=> $stable(flags_q));
  // R5
  edge_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> (pin_sync != pin_prev));
  // R6
  no_event_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] == 3'd0) |-> !edge_hit);
endmodule

bind tmr_pin_unit tmr_pin_unit_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .flags_q(flags_q),
  .stat_wr(stat_wr), .bus_wdata(bus_wdata), .edge_hit(edge_hit),
  .pin_sync(pin_sync), .pin_prev(pin_prev), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_tmr_pin_unit.sv
`timescale 1ns/1ps
module test_tmr_pin_unit;
  localparam int SYNC = 3;
  localparam logic [3:0] MODE_A = 4'h0;
  localparam logic [3:0] STAT_A = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, irq;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  tmr_pin_unit #(.SYNC_STAGES(SYNC)) i_tmr_pin_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pin(logic v);
    @(negedge clk);
    pin_in = v;
    repeat (SYNC + 1) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd_reg(MODE_A, r); check("R1 mode", r, 32'h0);
    rd_reg(STAT_A, r); check("R1 status", r, 32'h0);
    check("R1 oe", pin_oe, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_mask();
    logic [31:0] r;
    wr_reg(MODE_A, 32'hFFFF_FFF8);
    rd_reg(MODE_A, r); check("R2 mask", r, 32'h0003_0330);
    wr_reg(MODE_A, 32'h0000_0003);
    rd_reg(MODE_A, r); check("R2 fn", r, 32'h3);
    wr_reg(MODE_A, 32'h0);
  endtask

  task automatic t_gpio();
    wr_reg(MODE_A, 32'h24);
    check("R3 low oe", pin_oe, 1); check("R3 low lvl", pin_out, 0);
    wr_reg(MODE_A, 32'h34);
    check("R3 high oe", pin_oe, 1); check("R3 high lvl", pin_out, 1);
    wr_reg(MODE_A, 32'h04);
    check("R3 input", pin_oe, 0);
    wr_reg(MODE_A, 32'h31);
    check("R3 capture no drive", pin_oe, 0);
    wr_reg(MODE_A, 32'h33);
    check("R3 reserved no drive", pin_oe, 0);
    wr_reg(MODE_A, 32'h234);
    check("R4 od high", pin_oe, 0);
    wr_reg(MODE_A, 32'h224);
    check("R4 od low oe", pin_oe, 1); check("R4 od low lvl", pin_out, 0);
    wr_reg(MODE_A, 32'h0);
  endtask

  task automatic t_edges();
    logic [31:0] r;
    wr_reg(MODE_A, 32'h0001_0001);
    set_pin(1); rd_reg(STAT_A, r); check("R5 rising", r[0], 1);
    check("R10 level high", r[8], 1);
    wr_reg(STAT_A, 32'h1);
    set_pin(0); rd_reg(STAT_A, r); check("R5 rising ignores fall", r[0], 0);
    wr_reg(MODE_A, 32'h0002_0001);
    set_pin(1); rd_reg(STAT_A, r); check("R5 falling ignores rise", r[0], 0);
    set_pin(0); rd_reg(STAT_A, r); check("R5 falling", r[0], 1);
    wr_reg(STAT_A, 32'h1);
    wr_reg(MODE_A, 32'h0003_0001);
    set_pin(1); rd_reg(STAT_A, r); check("R5 both rise", r[0], 1);
    wr_reg(STAT_A, 32'h1);
    set_pin(0); rd_reg(STAT_A, r); check("R5 both fall", r[0], 1);
    wr_reg(STAT_A, 32'h1);
    wr_reg(MODE_A, 32'h0000_0001);
    set_pin(1); set_pin(0); rd_reg(STAT_A, r); check("R5 none", r[0], 0);
    wr_reg(MODE_A, 32'h0003_0000);
    set_pin(1); set_pin(0); rd_reg(STAT_A, r); check("R6 off", r[0], 0);
    wr_reg(MODE_A, 32'h0003_0004);
    set_pin(1); rd_reg(STAT_A, r); check("R6 gpio input", r[0], 1);
    wr_reg(STAT_A, 32'h0);
    rd_reg(STAT_A, r); check("R7 zero write keeps", r[0], 1);
    wr_reg(STAT_A, 32'hF);
    rd_reg(STAT_A, r); check("R7 clear", r[3:0], 4'h0);
  endtask

  task automatic t_collide();
    logic [31:0] r;
    wr_reg(MODE_A, 32'h0003_0001);
    @(negedge clk); pin_in = 1'b0;
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk); pin_in = 1'b1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    bus_addr = STAT_A; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    rd_reg(STAT_A, r); check("R8 set wins", r[0], 1);
    wr_reg(STAT_A, 32'h1);
    rd_reg(STAT_A, r); check("R8 clear after", r[0], 0);
  endtask

  task automatic t_irq();
    logic [31:0] r;
    wr_reg(MODE_A, 32'h0003_0001);
    set_pin(0); check("R9 flag no enable", irq, 0);
    wr_reg(MODE_A, 32'h0003_0101);
    check("R9 enabled", irq, 1);
    wr_reg(STAT_A, 32'h1);
    check("R9 cleared", irq, 0);
    @(negedge clk); pin_in = 1'b1;
    repeat (SYNC - 1) @(posedge clk);
    rd_reg(STAT_A, r); check("R10 lag old", r[8], 0);
    @(posedge clk);
    rd_reg(STAT_A, r); check("R10 lag new", r[8], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_mask();
    t_gpio();
    t_edges();
    t_collide();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule